// File: doc/BRIEF.md
# Circular Pin Event Recorder

This block watches twelve digital input pins and records every level change on a pin whose recording is enabled. Each record is eight bytes long and holds a sequence id, the pin index, the new level and a 40-bit timestamp. Records go into a circular store of `DEPTH` entries. Writing one record takes `COMMIT_CYCLES` clock cycles. While a write is in progress, new changes wait in a staging slot that belongs to their pin. When several slots are waiting, the lowest pin index is written first.

A host uses a byte-wide register port to read records one byte at a time. In the default mode the oldest record is removed once its last byte has been read. With the keep bit set, the host instead steps through the stored records and none is removed. When the store is full, a new record replaces the oldest one. Reading an address that does not exist, or asking for a record that is not there, returns 0xFF and sets a sticky error flag. The error flag stays set until the control register is written.

An active-low interrupt gives a one-cycle pulse on a change of any pin whose interrupt bit is set, and again each time the store becomes full. There are two resets. The manual reset clears only the volatile state. The power-on reset also clears the store pointers.

Top module: `event_ring_recorder`

## Requirements
- R1: After a change on a pin whose recording is enabled has been written, reading address 3 eight times returns these bytes in order: the sequence id, the pin index, the new level (0 or 1), then timestamp bytes 0 to 4, least significant byte first. The sequence id starts at 0 after either reset and goes up by one for each record written.
- R2: Records are written one at a time, each taking `COMMIT_CYCLES` cycles. Pending changes are taken in ascending pin order. The number of stored records, read at address 2, goes up only when a write completes.
- R3: Each pin has one staging slot. A change on a pin whose slot is still waiting is dropped, and the overflow count at address 10 goes up by one. This count saturates at 255.
- R4: When the keep bit (address 0, bit 0) is 0, the stored count and the oldest record do not change while bytes 1 to 7 are read. The eighth byte read removes the oldest record.
- R5: When the keep bit is 1, the eighth byte moves the read view to the next stored record and nothing is removed. Any write to address 0 puts the view back on the oldest record, at byte 0.
- R6: When a write starts while the store holds `DEPTH` records, the oldest record is discarded at once. The store therefore keeps the newest `DEPTH` records.
- R7: A read of addresses 11 to 15, or a read of address 3 when the view is past the last stored record, returns 0xFF and sets the error flag (address 1, bit 0). While the flag is set, address 3 returns 0xFF and does not advance. A write to address 0 clears the flag. The other status bits at address 1 are: bit 1 full, bit 2 empty, bit 3 write in progress.
- R8: `int_no` is low for one cycle after a change on a pin whose interrupt bit is set. The interrupt bits are at addresses 4 (pins 0-7) and 5 (pins 8-11). This happens whether or not the pin's recording bit is set; the recording bits are at addresses 6 and 7 and reset to all ones.
- R9: `int_no` is low for one cycle each time the store becomes full.
- R10: `rst_ni` clears the control, error, interrupt, recording and overflow state, the sequence id and the timestamp counter. It keeps the stored records, their pointers and their count.
- R11: Writing 1 to bit 1 of address 0 copies the present pin levels to addresses 8 (pins 0-7) and 9 (pins 8-11). This bit always reads back as 0.
- R12: The difference between the timestamps of two records equals the number of cycles between the two pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, active low; clears everything |
| rst_ni | input | 1 | Manual reset, active low; clears volatile state only |
| pins_i | input | NPINS | Monitored pins |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| int_no | output | 1 | Interrupt pulse, active low |

## Verification
The bench toggles each pin alone to check the record layout and the sequence ids. It then drops all twelve pins at once. This fills the store and then overwrites it, so a design that does not discard the oldest record, or writes pins out of order, returns the wrong pins and ids. The bench also reads beyond the stored records in keep mode and reads an empty store. A design that advances or clears the error flag on its own returns real bytes instead of 0xFF. Further cases are a second change on a pin that is still waiting, a manual reset with records stored, and a masked pin with recording disabled; these catch lost overflow counts, pointers that are wrongly cleared, and interrupts that wrongly depend on recording.

// File: rtl/event_ring_recorder.sv
module event_ring_recorder #(
  parameter int NPINS = 12,
  parameter int DEPTH = 8,
  parameter int COMMIT_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             por_ni,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pins_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [3:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output logic             int_no
);
  localparam int PW  = $clog2(DEPTH);
  localparam int CW  = $clog2(COMMIT_CYCLES);
  localparam int TSW = 40;
  localparam logic [3:0] A_CTRL = 4'd0, A_STAT = 4'd1, A_CNT = 4'd2, A_EV = 4'd3,
                         A_IENL = 4'd4, A_IENH = 4'd5, A_RENL = 4'd6, A_RENH = 4'd7,
                         A_SNPL = 4'd8, A_SNPH = 4'd9, A_OVF = 4'd10;

  logic rstv_n;
  assign rstv_n = rst_ni & por_ni;

  logic [NPINS-1:0] pins_q, evt, ien, ren, snap_q, slot_v, slot_lvl;
  logic [TSW-1:0]   ts_q, cur_ts;
  logic [TSW-1:0]   slot_ts [NPINS];
  logic             primed;
  logic [7:0]       ovf_q, seq_q, rdata_q;
  logic             busy_q, cur_lvl, keep_q, err_q, int_q, full_d;
  logic [CW-1:0]    cyc_q;
  logic [3:0]       cur_pin;
  logic [63:0]      mem [DEPTH];
  logic [PW-1:0]    rd_ptr, wr_ptr, ev_idx;
  logic [PW:0]      count_q, view_q;
  logic [2:0]       byte_q;

  assign evt = primed ? (pins_i ^ pins_q) : '0;

  logic       pick_v;
  logic [3:0] pick;
  always_comb begin
    pick_v = 1'b0;
    pick   = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (slot_v[i]) begin
        pick_v = 1'b1;
        pick   = 4'(i);
      end
    end
  end

  logic start, done, full, empty;
  logic [NPINS-1:0] start_mask, take, lost;
  assign start      = !busy_q && pick_v;
  assign done       = busy_q && (cyc_q == '0);
  assign full       = (count_q == (PW+1)'(DEPTH));
  assign empty      = (count_q == '0);
  assign start_mask = start ? (NPINS'(1) << pick) : '0;
  assign lost       = evt & ren & slot_v & ~start_mask;
  assign take       = evt & ren & ~lost;

  logic [8:0] ovf_sum;
  assign ovf_sum = {1'b0, ovf_q} + 9'($countones(lost));

  logic ev_rd, avail, ev_ok, pop, drop, rd_adv, bad_addr, set_err, ctrl_wr;
  assign ev_rd    = rd_en_i && rst_ni && (addr_i == A_EV);
  assign avail    = view_q < count_q;
  assign ev_ok    = ev_rd && !err_q && avail;
  assign pop      = ev_ok && (byte_q == 3'd7) && !keep_q;
  assign drop     = start && full && !pop;
  assign rd_adv   = pop || drop;
  assign bad_addr = rd_en_i && (addr_i > A_OVF);
  assign set_err  = bad_addr || (ev_rd && !err_q && !avail);
  assign ctrl_wr  = wr_en_i && (addr_i == A_CTRL);

  assign ev_idx = rd_ptr + view_q[PW-1:0];
  logic [63:0] ev_word;
  assign ev_word = mem[ev_idx];

  logic [15:0] ien16, ren16, snap16;
  assign ien16  = 16'(ien);
  assign ren16  = 16'(ren);
  assign snap16 = 16'(snap_q);

  logic [7:0] rd_val;
  always_comb begin
    case (addr_i)
      A_CTRL:  rd_val = {7'b0, keep_q};
      A_STAT:  rd_val = {4'b0, busy_q, empty, full, err_q};
      A_CNT:   rd_val = 8'(count_q);
      A_EV:    rd_val = (err_q || !avail) ? 8'hFF : ev_word[{byte_q, 3'b000} +: 8];
      A_IENL:  rd_val = ien16[7:0];
      A_IENH:  rd_val = ien16[15:8];
      A_RENL:  rd_val = ren16[7:0];
      A_RENH:  rd_val = ren16[15:8];
      A_SNPL:  rd_val = snap16[7:0];
      A_SNPH:  rd_val = snap16[15:8];
      A_OVF:   rd_val = ovf_q;
      default: rd_val = 8'hFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (rd_adv) rd_ptr <= rd_ptr + 1'b1;
      if (done)   wr_ptr <= wr_ptr + 1'b1;
      count_q <= count_q + (PW+1)'(done) - (PW+1)'(rd_adv);
    end
  end

  always_ff @(posedge clk_i) begin
    if (done) mem[wr_ptr] <= {cur_ts, 7'b0, cur_lvl, 4'b0, cur_pin, seq_q};
  end

  always_ff @(posedge clk_i or negedge rstv_n) begin
    if (!rstv_n) begin
      pins_q   <= '0;
      primed   <= 1'b0;
      ts_q     <= '0;
      slot_v   <= '0;
      slot_lvl <= '0;
      for (int i = 0; i < NPINS; i++) slot_ts[i] <= '0;
      ovf_q    <= '0;
      busy_q   <= 1'b0;
      cyc_q    <= '0;
      cur_pin  <= '0;
      cur_lvl  <= 1'b0;
      cur_ts   <= '0;
      seq_q    <= '0;
      keep_q   <= 1'b0;
      err_q    <= 1'b0;
      byte_q   <= '0;
      view_q   <= '0;
      ien      <= '0;
      ren      <= '1;
      snap_q   <= '0;
      rdata_q  <= '0;
      int_q    <= 1'b0;
      full_d   <= 1'b1;
    end else begin
      pins_q <= pins_i;
      primed <= 1'b1;
      ts_q   <= ts_q + 1'b1;
      for (int i = 0; i < NPINS; i++) begin
        if (start_mask[i]) slot_v[i] <= 1'b0;
        if (take[i]) begin
          slot_v[i]   <= 1'b1;
          slot_lvl[i] <= pins_i[i];
          slot_ts[i]  <= ts_q;
        end
      end
      ovf_q <= ovf_sum[8] ? 8'hFF : ovf_sum[7:0];

      if (start) begin
        busy_q  <= 1'b1;
        cyc_q   <= CW'(COMMIT_CYCLES - 1);
        cur_pin <= pick;
        cur_lvl <= slot_lvl[pick];
        cur_ts  <= slot_ts[pick];
      end else if (busy_q) begin
        if (cyc_q == '0) begin
          busy_q <= 1'b0;
          seq_q  <= seq_q + 1'b1;
        end else begin
          cyc_q <= cyc_q - 1'b1;
        end
      end

      if (ctrl_wr) begin
        keep_q <= wdata_i[0];
        err_q  <= 1'b0;
        byte_q <= '0;
        view_q <= '0;
        if (wdata_i[1]) snap_q <= pins_i;
      end else begin
        if (set_err) err_q <= 1'b1;
        if (drop) begin
          byte_q <= '0;
          view_q <= '0;
        end else if (ev_ok) begin
          byte_q <= byte_q + 1'b1;
          if (byte_q == 3'd7 && keep_q) view_q <= view_q + 1'b1;
        end
      end

      if (wr_en_i) begin
        case (addr_i)
          A_IENL: ien <= NPINS'({ien16[15:8], wdata_i});
          A_IENH: ien <= NPINS'({wdata_i, ien16[7:0]});
          A_RENL: ren <= NPINS'({ren16[15:8], wdata_i});
          A_RENH: ren <= NPINS'({wdata_i, ren16[7:0]});
          default: ;
        endcase
      end

      if (rd_en_i) rdata_q <= rd_val;
      int_q  <= (|(evt & ien)) || (full && !full_d);
      full_d <= full;
    end
  end

  assign rdata_o = rdata_q;
  assign int_no  = ~int_q;

  p_err_filler_r7: assert property (@(posedge clk_i) disable iff (!rstv_n)
    (rd_en_i && addr_i == A_EV && err_q) |=> (rdata_o == 8'hFF));
  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rstv_n)
    (err_q && !ctrl_wr) |=> err_q);
  p_keep_nopop_r5: assert property (@(posedge clk_i) disable iff (!rstv_n)
    (ev_rd && keep_q && !full) |=> (count_q >= $past(count_q)));
  p_no_early_pop_r4: assert property (@(posedge clk_i) disable iff (!rstv_n)
    (ev_rd && !keep_q && byte_q != 3'd7 && !full) |=> $stable(rd_ptr));
  p_write_in_commit_r2: assert property (@(posedge clk_i) disable iff (!rstv_n)
    (wr_ptr != $past(wr_ptr)) |-> $past(busy_q));
  p_ovf_monotone_r3: assert property (@(posedge clk_i) disable iff (!rstv_n)
    1'b1 |=> (ovf_q >= $past(ovf_q)));
  p_count_bound_r6: assert property (@(posedge clk_i) disable iff (!rstv_n)
    count_q <= (PW+1)'(DEPTH));
endmodule

// File: tb/test_event_ring_recorder.sv
`timescale 1ns/1ps
module test_event_ring_recorder;
  localparam int NP = 12, DP = 8, CC = 16;
  localparam int SPAN = CC + 1;

  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic int_n;
  int tests = 0, fails = 0, int_cnt = 0;

  event_ring_recorder #(.NPINS(NP), .DEPTH(DP), .COMMIT_CYCLES(CC)) i_event_ring_recorder (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n), .pins_i(pins), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .int_no(int_n));

  always #2.5 clk = ~clk;
  always @(negedge clk) if (!int_n) int_cnt++;

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_event(output logic [7:0] b [8]);
    for (int k = 0; k < 8; k++) rd(4'd3, b[k]);
  endtask

  function automatic longint ts_of(input logic [7:0] b [8]);
    return {b[7], b[6], b[5], b[4], b[3]};
  endfunction

  initial begin
    logic [7:0] d;
    logic [7:0] ev [8];
    logic [7:0] ev2 [8];
    int i0;
    longint t0;
    cyc(4);
    por_n = 1'b1; rst_n = 1'b1;
    cyc(2);

    // R10 reset values
    rd(4'd1, d); chk("R10 status after reset", d, 8'h04);
    rd(4'd2, d); chk("R10 count after reset", d, 0);
    rd(4'd4, d); chk("R10 ien low", d, 0);
    rd(4'd6, d); chk("R10 ren low", d, 8'hFF);
    rd(4'd7, d); chk("R10 ren high", d, 8'h0F);
    rd(4'd10, d); chk("R10 ovf", d, 0);
    chk("R8 no int at reset", int_cnt, 0);

    // R1/R4/R8 sweep over every pin
    wr(4'd4, 8'hFF); wr(4'd5, 8'h0F);
    for (int p = 0; p < NP; p++) begin
      i0 = int_cnt;
      @(negedge clk); pins[p] = 1'b1;
      cyc(SPAN + 5);
      chk("R8 masked pin int", int_cnt - i0, 1);
      rd(4'd2, d); chk("R2 count after one write", d, 1);
      for (int k = 0; k < 7; k++) rd(4'd3, ev[k]);
      rd(4'd2, d); chk("R4 count before eighth byte", d, 1);
      rd(4'd3, ev[7]);
      chk("R1 seq id", ev[0], p);
      chk("R1 pin index", ev[1], p);
      chk("R1 level", ev[2], 1);
      rd(4'd2, d); chk("R4 pop after eighth byte", d, 0);
    end
    wr(4'd4, 8'h00); wr(4'd5, 8'h00);

    // R2/R6/R9 all pins fall together: fill and overwrite
    i0 = int_cnt;
    @(negedge clk); pins = '0;
    cyc(NP * SPAN + 20);
    rd(4'd2, d); chk("R6 count saturates at depth", d, DP);
    chk("R9 full pulses", int_cnt - i0, 5);
    rd(4'd1, d); chk("R7 status full", d, 8'h02);
    wr(4'd0, 8'h01);
    for (int k = 0; k < DP; k++) begin
      rd_event(ev);
      if (k == 0) t0 = ts_of(ev);
      chk("R6 newest ids kept", ev[0], 16 + k);
      chk("R2 ascending pin order", ev[1], 4 + k);
      chk("R1 level low", ev[2], 0);
      chk("R12 same capture time", ts_of(ev), t0);
    end
    rd(4'd2, d); chk("R5 keep leaves count", d, DP);
    rd(4'd3, d); chk("R7 over-read filler", d, 8'hFF);
    rd(4'd1, d); chk("R7 err flag set", d, 8'h03);
    rd(4'd3, d); chk("R7 filler while err", d, 8'hFF);
    wr(4'd0, 8'h00);
    rd(4'd1, d); chk("R7 err cleared by ctrl", d, 8'h02);
    for (int k = 0; k < DP; k++) begin
      rd_event(ev);
      chk("R5 rewind then destructive ids", ev[0], 16 + k);
    end
    rd(4'd2, d); chk("R4 all popped", d, 0);
    rd(4'd3, d); chk("R7 empty read filler", d, 8'hFF);
    rd(4'd1, d); chk("R7 err and empty", d, 8'h05);
    wr(4'd0, 8'h00);
    rd(4'd12, d); chk("R7 illegal addr filler", d, 8'hFF);
    rd(4'd1, d); chk("R7 illegal addr err", d, 8'h05);
    wr(4'd0, 8'h00);

    // R3 overflow on a waiting slot
    @(negedge clk); pins[1] = 1'b1;
    cyc(2);
    pins[0] = 1'b1;
    cyc(2);
    pins[0] = 1'b0;
    cyc(3 * SPAN);
    rd(4'd10, d); chk("R3 overflow count", d, 1);
    rd(4'd2, d); chk("R3 two records", d, 2);

    // R10 manual reset keeps store
    @(negedge clk); rst_n = 1'b0;
    cyc(2); rst_n = 1'b1;
    cyc(2);
    rd(4'd2, d); chk("R10 count kept", d, 2);
    rd(4'd10, d); chk("R10 ovf cleared", d, 0);
    rd(4'd1, d); chk("R10 status", d, 8'h00);
    rd_event(ev);
    chk("R10 first kept id", ev[0], 24);
    chk("R3 first pin", ev[1], 1);
    rd_event(ev);
    chk("R10 second kept id", ev[0], 25);
    chk("R3 second pin", ev[1], 0);
    chk("R3 second level", ev[2], 1);
    @(negedge clk); pins[7] = 1'b1;
    cyc(SPAN + 5);
    rd_event(ev);
    chk("R10 seq restarts", ev[0], 0);
    chk("R1 pin seven", ev[1], 7);

    // R8 interrupt independent of recording
    wr(4'd6, 8'h00); wr(4'd7, 8'h00); wr(4'd4, 8'h08);
    i0 = int_cnt;
    @(negedge clk); pins[3] = ~pins[3];
    cyc(3);
    chk("R8 int with recording off", int_cnt - i0, 1);
    @(negedge clk); pins[2] = ~pins[2];
    cyc(3);
    chk("R8 unmasked pin quiet", int_cnt - i0, 1);
    cyc(SPAN + 5);
    rd(4'd2, d); chk("R8 nothing recorded", d, 0);
    wr(4'd6, 8'hFF); wr(4'd7, 8'h0F); wr(4'd4, 8'h00);

    // R12 timestamp spacing
    @(negedge clk); pins[5] = ~pins[5];
    cyc(37);
    pins[6] = ~pins[6];
    cyc(2 * SPAN + 10);
    rd_event(ev);
    rd_event(ev2);
    chk("R12 first pin", ev[1], 5);
    chk("R12 second pin", ev2[1], 6);
    chk("R12 timestamp delta", ts_of(ev2) - ts_of(ev), 37);

    // R11 snapshot
    @(negedge clk); pins = 12'hA5C;
    cyc(2);
    wr(4'd0, 8'h02);
    rd(4'd8, d); chk("R11 snap low", d, 8'h5C);
    rd(4'd9, d); chk("R11 snap high", d, 8'h0A);
    rd(4'd0, d); chk("R11 snap bit reads zero", d, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule